// File: doc/BRIEF.md
# Reference Stream Stack Distance Profiler

This block watches a stream of byte addresses and measures how much locality the stream has. Each accepted address is reduced to a block number by dropping the offset bits of a power-of-two line size. The block then looks the number up in a bounded recency list, which is kept in least-recently-used order. The position where it finds the block is the LRU stack distance: the count of distinct other blocks referenced since this block was last seen. A block that is not in the list is reported with an "infinite" flag. This covers a first touch and also a block that has been pushed out of the bounded list.

The distance tells directly whether a fully associative LRU cache of a given size would hit. The block also raises a hit flag for one cache size chosen by parameter. A histogram keeps a count for every finite distance plus a count for infinite references, and software or a test harness reads it one bin at a time through a registered select port. An address is accepted on any cycle where `in_valid` and `in_ready` are both high. The list update and the histogram increment both finish in that single cycle, so the input never stalls once reset is released.

Top module: `stack_dist_profiler`

## Requirements
- R1: The block number of a reference is the address shifted right by log2(LINE_BYTES). The offset bits below that do not affect any result.
- R2: For a block that is held in the recency list, `out_dist` is the number of distinct blocks referenced since its previous reference. A reference repeated back to back gives 0.
- R3: A reference to a block that is not in the list sets `out_inf` to 1 and `out_dist` to 0. For a finite result `out_inf` is 0.
- R4: `out_hit` is 1 exactly when the result is finite and `out_dist` is less than HIT_LINES.
- R5: `out_valid` is high for one cycle, in the cycle after each accepted reference, and stays low when nothing was accepted. The other result outputs are valid in that same cycle.
- R6: `in_ready` is low while reset is asserted and high from the first cycle after reset is released.
- R7: The list holds DEPTH blocks. After a block is referenced, DEPTH distinct other blocks push it out, and its next reference is infinite. After DEPTH-1 distinct other blocks it still gives distance DEPTH-1.
- R8: The histogram has DEPTH+1 bins. Bin d counts finite distance d, and bin DEPTH counts infinite references. Each accepted reference adds one to exactly one bin.
- R9: A bin that has reached 2^CNT_W-1 keeps that value on further increments.
- R10: `hist_count` shows the bin chosen by `hist_sel` one cycle after the select is applied, including all references accepted up to that edge. A select above DEPTH reads 0.
- R11: Reset empties the recency list and clears every bin. The first reference after reset is infinite, whatever came before it.
- R12: A cycle without `in_valid` leaves the list and the histogram unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Block accepts an address this cycle |
| in_addr | input | ADDR_W | Byte address of the reference |
| out_valid | output | 1 | Result for the previous accepted reference |
| out_dist | output | POS_W | Stack distance (0 when infinite) |
| out_inf | output | 1 | Reference was not in the recency list |
| out_hit | output | 1 | Would hit a HIT_LINES-line fully associative LRU cache |
| hist_sel | input | BIN_W | Histogram bin to read |
| hist_count | output | CNT_W | Registered count of the selected bin |

## Verification
A reference accepted at a rising edge produces its distance, infinite flag and hit flag in the register stage that same edge loads. The bench therefore drives each address just after a falling edge and compares the result at the next falling edge, which puts exactly one register between stimulus and check. Histogram increments land on the accepting edge. The bin readout adds one more register, so the bench applies `hist_sel` at a falling edge and compares one full cycle later. The reference model updates only when a reference is handed over, so back-to-back streams and idle gaps both line up with the design.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // Width of an index able to address n items, never zero.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sdp_recency_list.sv
module sdp_recency_list
  import sdp_pkg::*;
#(
  parameter int unsigned BLK_W = 29,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned POS_W = idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [BLK_W-1:0] blk,
  output logic             found,
  output logic [POS_W-1:0] pos
);
  logic [BLK_W-1:0] tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] match;
  logic [POS_W-1:0] last_pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = vld_q[i] && (tag_q[i] == blk);
      if (match[i]) pos = pos | POS_W'(i);
    end
    found = |match;
  end

  // Entries at or above the hit position slide down one slot; on a miss all do.
  assign last_pos = found ? pos : POS_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else if (upd) begin
      tag_q[0] <= blk;
      vld_q[0] <= 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        if (POS_W'(i) <= last_pos) begin
          tag_q[i] <= tag_q[i-1];
          vld_q[i] <= vld_q[i-1];
        end
      end
    end
  end

  // R2: a block lives in at most one slot
  a_r2_unique_entry: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
  // R2: the newest reference sits at the top of the list
  a_r2_top_is_newest: assert property (@(posedge clk) disable iff (rst)
    upd |=> (vld_q[0] && tag_q[0] == $past(blk)));
  // R12: no update leaves the list alone
  a_r12_list_hold: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(vld_q));
endmodule

// File: rtl/sdp_histogram.sv
module sdp_histogram
  import sdp_pkg::*;
#(
  parameter int unsigned NBINS = 9,
  parameter int unsigned BIN_W = idx_w(NBINS),
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [BIN_W-1:0] inc_bin,
  input  logic [BIN_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] bin_q [NBINS];

  generate
    for (genvar g = 0; g < NBINS; g++) begin : g_bin
      always_ff @(posedge clk) begin
        if (rst) bin_q[g] <= '0;
        else if (inc && inc_bin == BIN_W'(g) && bin_q[g] != CMAX)
          bin_q[g] <= bin_q[g] + 1'b1;
      end
      // R8: a bin moves only when it is the one addressed by an increment
      a_r8_bin_on_inc: assert property (@(posedge clk) disable iff (rst)
        (bin_q[g] != $past(bin_q[g])) |-> ($past(inc) && $past(inc_bin) == BIN_W'(g)));
      // R9: a full bin stays full
      a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (bin_q[g] == CMAX) |=> (bin_q[g] == CMAX));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rd_cnt <= '0;
    else if (32'(rd_sel) < NBINS) rd_cnt <= bin_q[rd_sel];
    else rd_cnt <= '0;
  end
endmodule

// File: rtl/stack_dist_profiler.sv
module stack_dist_profiler
  import sdp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 8,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned HIT_LINES  = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned BLK_W = ADDR_W - OFF_W,
  localparam int unsigned POS_W = idx_w(DEPTH),
  localparam int unsigned BIN_W = idx_w(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [POS_W-1:0]  out_dist,
  output logic              out_inf,
  output logic              out_hit,
  input  logic [BIN_W-1:0]  hist_sel,
  output logic [CNT_W-1:0]  hist_count
);
  logic             acc;
  logic [BLK_W-1:0] blk;
  logic             found;
  logic [POS_W-1:0] pos;
  logic [BIN_W-1:0] bin;

  assign acc = in_valid && in_ready;
  assign blk = in_addr[ADDR_W-1:OFF_W];
  assign bin = found ? BIN_W'(pos) : BIN_W'(DEPTH);

  sdp_recency_list #(.BLK_W(BLK_W), .DEPTH(DEPTH), .POS_W(POS_W)) u_list (
    .clk(clk), .rst(rst), .upd(acc), .blk(blk), .found(found), .pos(pos)
  );

  sdp_histogram #(.NBINS(DEPTH + 1), .BIN_W(BIN_W), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .inc(acc), .inc_bin(bin),
    .rd_sel(hist_sel), .rd_cnt(hist_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_dist  <= '0;
      out_inf   <= 1'b0;
      out_hit   <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= acc;
      if (acc) begin
        out_inf  <= !found;
        out_dist <= found ? pos : '0;
        out_hit  <= found && (32'(pos) < HIT_LINES);
      end
    end
  end

  // R5: every accepted reference yields a result next cycle
  a_r5_result_follows: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);
  // R5: no result without an accepted reference
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !out_valid);
  // R4: an infinite result is never a hit and carries distance zero
  a_r4_inf_no_hit: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_inf) |-> (!out_hit && out_dist == '0));
  // R6: ready rises once reset is gone
  a_r6_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);
endmodule

// File: tb/stack_dist_profiler_bench.sv
`timescale 1ns/1ps
module stack_dist_profiler_bench;
  localparam int DEPTH = 8;
  localparam int HITL  = 4;
  localparam int CNTW  = 5;
  localparam int CMAX  = (1 << CNTW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic out_valid, out_inf, out_hit;
  logic [2:0] out_dist;
  logic [3:0] hist_sel = '0;
  logic [CNTW-1:0] hist_count;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int mtag [DEPTH];
  bit mvld [DEPTH];
  int mbin [DEPTH+1];

  always #2 clk = ~clk;

  stack_dist_profiler #(.ADDR_W(32), .LINE_BYTES(8), .DEPTH(DEPTH),
                        .HIT_LINES(HITL), .CNT_W(CNTW)) u_stack_dist_profiler (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_dist(out_dist),
    .out_inf(out_inf), .out_hit(out_hit), .hist_sel(hist_sel),
    .hist_count(hist_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin mtag[i] = 0; mvld[i] = 0; end
    for (int i = 0; i <= DEPTH; i++) mbin[i] = 0;
  endtask

  // Reference model: returns distance, -1 for infinite, and updates state.
  task automatic model_ref(input int b, output int d);
    int last;
    d = -1;
    for (int i = 0; i < DEPTH; i++) if (mvld[i] && mtag[i] == b) d = i;
    last = (d < 0) ? DEPTH - 1 : d;
    for (int i = DEPTH - 1; i >= 1; i--)
      if (i <= last) begin mtag[i] = mtag[i-1]; mvld[i] = mvld[i-1]; end
    mtag[0] = b; mvld[0] = 1;
    if (d < 0) begin if (mbin[DEPTH] < CMAX) mbin[DEPTH]++; end
    else if (mbin[d] < CMAX) mbin[d]++;
  endtask

  // Called and returns at a falling edge; leaves in_valid low.
  task automatic send(input logic [31:0] a, input int want);
    int d;
    model_ref(int'(a >> 3), d);
    in_valid = 1'b1; in_addr = a;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R5 out_valid after accept", int'(out_valid), 1);
    if (want != -2) chk((want < 0) ? out_inf : (!out_inf && out_dist == want),
                        "R2/R3 directed distance", out_inf ? -1 : int'(out_dist), want);
    chk(out_inf == (d < 0), "R3 infinite flag", int'(out_inf), int'(d < 0));
    if (d >= 0) chk(int'(out_dist) == d, "R2 distance", int'(out_dist), d);
    else chk(out_dist == 0, "R3 inf distance zero", int'(out_dist), 0);
    chk(out_hit == (d >= 0 && d < HITL), "R4 hit flag", int'(out_hit), int'(d >= 0 && d < HITL));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_addr = $urandom;
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R5/R12 no result when idle", int'(out_valid), 0);
    end
  endtask

  task automatic read_bin(input int sel, input int exp, input string req);
    hist_sel = 4'(sel);
    @(posedge clk); @(negedge clk);
    chk(int'(hist_count) == exp, req, int'(hist_count), exp);
  endtask

  task automatic check_all_bins(input string req);
    for (int b = 0; b <= DEPTH; b++) read_bin(b, mbin[b], req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R6 ready low in reset", int'(in_ready), 0);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R5 no result after reset", int'(out_valid), 0);
  endtask

  initial begin
    int w[8];
    void'($urandom(32'd1234));
    model_clear();
    @(negedge clk);
    do_reset();
    check_all_bins("R11 bins clear after reset");

    // R1 R2 R3: offsets inside a line fold onto the block
    w = '{-1, -1, 1, 0, 1, -1, -1, 3};
    send(32'd0, w[0]); send(32'd8, w[1]); send(32'd4, w[2]); send(32'd4, w[3]);
    send(32'd12, w[4]); send(32'd16, w[5]); send(32'd32, w[6]); send(32'd4, w[7]);
    idle(2);
    check_all_bins("R8 bins after directed stream");
    read_bin(15, 0, "R10 select above DEPTH reads zero");

    // R7: DEPTH-1 others keeps the block; DEPTH others evicts it
    do_reset();
    send(32'h1000, -1);
    for (int i = 1; i < DEPTH; i++) send(32'h1000 + 32'(i) * 8, -1);
    send(32'h1000, DEPTH - 1);
    for (int i = 1; i <= DEPTH; i++) send(32'h2000 + 32'(i) * 8, -1);
    send(32'h1000, -1);
    idle(1);
    check_all_bins("R7 bins after eviction test");

    // Random stream with gaps; drives bins into saturation (R9)
    for (int n = 0; n < 600; n++) begin
      send(32'(($urandom % 11) * 8 + ($urandom % 8)), -2);
      if ($urandom % 6 == 0) idle(1 + $urandom % 2);
    end
    idle(1);
    check_all_bins("R9 R10 bins after random stream");

    // R11: reset mid-run forgets everything
    do_reset();
    check_all_bins("R11 bins clear after mid-run reset");
    send(32'd0, -1);
    idle(1);
    read_bin(DEPTH, 1, "R11 first reference after reset counted infinite");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule